// File: doc/BRIEF.md
# Cycle Count Trailer Serializer

This block produces the cycle-count trailer that follows a branch packet when cycle-accurate tracing is on. A free-running counter measures the clock edges between consecutive reported branches. When the packet encoder hands over a branch on the start handshake, the block snapshots the counter, clears it and then sends the snapshot as 1 to 5 bytes on a valid/ready byte stream. Bytes that would only hold leading zeros are never sent.

The first byte holds four count bits and each later byte holds seven, so 32 bits fit in five bytes. The counter does not wrap: once it reaches the top of its range it stays there. A saturated counter is reported as the reserved all-ones code, meaning "overflow", so the largest ordinary count is one less than that. The enable input follows the cycle-accurate control bit. While it is low, branch handshakes are accepted and no bytes are produced.

Top module: `cyc_count_serializer`

## Requirements
- R1: After reset, out_valid is 0, start_ready is 1 and the internal counter is 0.
- R2: While cyc_en is 0, a start handshake is accepted (start_ready 1) and produces no byte on the output. The counter is held at 0, so the first count after cyc_en rises again measures only enabled cycles.
- R3: The counter stops at the all-ones value of its CTR_W bits. A snapshot taken there is reported as the overflow code 0xFFFFFFFF: five bytes, 0xF8 0xFF 0xFF 0xFF 0x7F.
- R4: The number of bytes depends on the highest set bit of the reported value. Bits 3..0 give 1 byte, 10..4 give 2, 17..11 give 3, 24..18 give 4 and 31..25 give 5.
- R5: Every byte has bit 7 set when another byte follows and clear on the last byte. Byte 0 carries value[3:0] in bits 6..3 and 0 in bits 2..0. Byte k (k of 1 or more) carries value[4+7(k-1)+6 : 4+7(k-1)] in bits 6..0.
- R6: A count of 0 is legal and is sent as the single byte 0x00. A handshake taken on the first edge after reset reports 0.
- R7: The value reported for a handshake is the number of enabled clock edges strictly between it and the previous accepted handshake, or reset. Counting continues while the previous trailer is being sent.
- R8: The first byte appears on the cycle after the handshake. start_ready is 0 until the last byte is taken. While out_ready is 0, out_valid stays 1 and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Cycle-accurate tracing enable |
| start_valid | input | 1 | Branch reported by the packet encoder |
| start_ready | output | 1 | Block can take a branch |
| out_data | output | 8 | Count byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Downstream takes the byte |

## Verification
The bench places counts on each side of every byte-length boundary it can reach: 15 and 16, 2047 and 2048, and zero. A wrong length table would drop a significant byte or add a zero byte at those points. It waits past saturation with a narrow counter. A counter that wraps would then report a small value instead of the five-byte overflow code. It stalls the output mid-trailer to catch bytes that change or advance under backpressure. It also checks that the count after a trailer includes the serialization cycles and that disabled handshakes leave the output silent.

// File: rtl/cyc_count_serializer.sv
module cyc_count_serializer #(
  parameter int CTR_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       start_valid,
  output logic       start_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready
);
  localparam logic [CTR_W-1:0] CNT_MAX = '1;

  logic [CTR_W-1:0] cnt;
  logic             busy;
  logic [31:0]      val;
  logic [2:0]       idx;
  logic [2:0]       last;
  logic [31:0]      snap;
  logic [2:0]       snap_last;
  logic             accept, take, fire;

  assign start_ready = !busy;
  assign out_valid   = busy;
  assign accept      = start_valid && !busy;
  assign take        = accept && cyc_en;
  assign fire        = busy && out_ready;

  assign snap = (cnt == CNT_MAX) ? 32'hFFFF_FFFF : 32'(cnt);

  always_comb begin
    if      (|snap[31:25]) snap_last = 3'd4;
    else if (|snap[24:18]) snap_last = 3'd3;
    else if (|snap[17:11]) snap_last = 3'd2;
    else if (|snap[10:4])  snap_last = 3'd1;
    else                   snap_last = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (!cyc_en || accept) cnt <= '0;
    else if (cnt != CNT_MAX)    cnt <= cnt + CTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      val  <= '0;
      idx  <= '0;
      last <= '0;
    end else if (take) begin
      busy <= 1'b1;
      val  <= snap;
      idx  <= '0;
      last <= snap_last;
    end else if (fire) begin
      if (idx == last) busy <= 1'b0;
      else             idx  <= idx + 3'd1;
    end
  end

  logic more;
  assign more = (idx != last);

  always_comb begin
    case (idx)
      3'd0:    out_data = {more, val[3:0], 3'b000};
      3'd1:    out_data = {more, val[10:4]};
      3'd2:    out_data = {more, val[17:11]};
      3'd3:    out_data = {more, val[24:18]};
      default: out_data = {more, val[31:25]};
    endcase
  end
endmodule

// File: rtl/cyc_count_serializer_sva.sv
module cyc_count_serializer_sva #(
  parameter int CTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             start_valid,
  input logic             start_ready,
  input logic [7:0]       out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       idx,
  input logic [CTR_W-1:0] cnt
);
  localparam logic [CTR_W-1:0] CNT_MAX = '1;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_first_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready && cyc_en |=> out_valid);

  p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready && !cyc_en |=> !out_valid);

  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_data[7] |=> !out_valid);

  p_cont_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_data[7] |=> out_valid);

  p_pad_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == 3'd0 |-> out_data[2:0] == 3'b000);

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && cnt == CNT_MAX && !(start_valid && start_ready) |=> cnt == CNT_MAX);
endmodule

bind cyc_count_serializer cyc_count_serializer_sva #(.CTR_W(CTR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .start_valid(start_valid),
  .start_ready(start_ready), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .idx(idx), .cnt(cnt)
);

// File: tb/test_cyc_count_serializer.sv
module test_cyc_count_serializer;
  localparam int W = 14;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b1;
  logic start_valid = 1'b0;
  logic out_ready = 1'b1;
  logic start_ready, out_valid;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int since = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cyc_count_serializer #(.CTR_W(W)) i_cyc_count_serializer (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .start_valid(start_valid),
    .start_ready(start_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  // R7 reference: enabled edges since last accepted handshake, saturating
  always @(posedge clk) begin
    if (!rst_n || !cyc_en)             since <= 0;
    else if (start_valid && start_ready) since <= 0;
    else if (since != MAXV)             since <= since + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [31:0] v);
    if (|v[31:25]) return 5;
    if (|v[24:18]) return 4;
    if (|v[17:11]) return 3;
    if (|v[10:4])  return 2;
    return 1;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [31:0] v, input int i);
    logic c;
    c = (i < exp_len(v) - 1);
    if (i == 0) return {c, v[3:0], 3'b000};
    return {c, v[4 + 7*(i-1) +: 7]};
  endfunction

  task automatic recv(input logic [31:0] v, input string req);
    int n;
    n = exp_len(v);
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      chk({req, " byte"}, 32'(out_data), 32'(exp_byte(v, i)));
      @(negedge clk);
    end
    chk({req, " end of trailer"}, 32'(out_valid), 32'd0);
  endtask

  task automatic branch(input string req);
    logic [31:0] v;
    chk({req, " ready before start"}, 32'(start_ready), 32'd1);
    v = (since == MAXV) ? 32'hFFFF_FFFF : 32'(since);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    recv(v, req);
  endtask

  task automatic branch_at(input int k, input string req);
    while (since != k) @(negedge clk);
    branch(req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 start_ready in reset", 32'(start_ready), 32'd1);
    rst_n = 1'b1;
    branch("R6 zero count after reset");
  endtask

  task automatic t_lengths();
    branch_at(15, "R4 count 15 one byte");
    branch_at(16, "R4 count 16 two bytes");
    branch_at(2047, "R5 count 2047 two bytes");
    branch_at(2048, "R4 count 2048 three bytes");
    branch_at(300, "R5 count 300");
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    while (since != 2100) @(negedge clk);
    v = 32'd2100;
    out_ready = 1'b0;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 held valid", 32'(out_valid), 32'd1);
      chk("R8 held byte0", 32'(out_data), 32'(exp_byte(v, 0)));
      chk("R8 ready low while busy", 32'(start_ready), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    recv(v, "R8 after stall");
    branch("R7 count includes serialization");
  endtask

  task automatic t_disable();
    cyc_en = 1'b0;
    @(negedge clk);
    start_valid = 1'b1;
    chk("R2 ready while disabled", 32'(start_ready), 32'd1);
    @(negedge clk);
    start_valid = 1'b0;
    chk("R2 no byte when disabled", 32'(out_valid), 32'd0);
    repeat (5) @(negedge clk);
    chk("R2 still silent", 32'(out_valid), 32'd0);
    cyc_en = 1'b1;
    repeat (7) @(negedge clk);
    chk("R2 count restarted", 32'(since), 32'd7);
    branch("R2 first count after enable");
  endtask

  task automatic t_overflow();
    while (since != MAXV) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R3 saturated reference", 32'(since), 32'(MAXV));
    branch("R3 overflow code");
    branch("R7 after overflow");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_lengths();
    t_backpressure();
    t_disable();
    t_overflow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule